// File: doc/BRIEF.md
# Circular-Buffer FIR Multiply-Accumulate Engine

This block is a time-multiplexed finite impulse response filter. Each accepted input sample triggers the computation of one output, y[n] = sum over k of h[k]·x[n−k], using a single multiply-accumulate unit that is stepped once per tap. The delay line is never shifted. Incoming samples go into a circular history memory at a wrapping write pointer. A second pointer walks backwards from the newest entry while a coefficient pointer walks forwards from tap 0, so every cycle pairs x[n−k] with h[k].

The sample and coefficient stores are two separate register arrays with synchronous reads, so one operand of each kind arrives every cycle. The multiply-accumulate unit merges the partial products and the running sum in one carry-save reduction, and only one carry-propagate adder sits at its end. The wide sum is rounded and saturated to the sample width before it is registered at the output. Coefficients are loaded through a simple write port while the engine is idle.

Top module: `fir_mac_engine`

## Requirements
- R1: While reset is high and for exactly TAPS clock edges after it falls, both memories are swept to zero and in_ready is low. During reset and that sweep out_valid is low and out_data reads zero.
- R2: out_valid is a single-cycle pulse that rises TAPS+1 clock edges after the edge that accepted a sample (in_valid and in_ready both high).
- R3: in_ready falls after an accepting edge and stays low until the cycle in which out_valid is high, when it is high again. in_valid and in_data have no effect while in_ready is low, so a continuously asserted in_valid yields one output every TAPS+2 cycles.
- R4: out_data is the signed accumulator plus 2^(FRAC−1), arithmetically shifted right by FRAC (FRAC = 15 by default, so coefficients are Q1.15). The result is two's complement on 16 bits.
- R5: A rounded result above 32767 gives 32767, and one below −32768 gives −32768.
- R6: The newest sample multiplies coefficient 0 and the sample k steps older multiplies coefficient k. Positions older than the first sample after reset count as zero.
- R7: Only the newest TAPS samples take part. A sample TAPS or more steps older has no effect on the output.
- R8: The accumulator starts from zero for every output, so the same history and coefficients always give the same result.
- R9: While in_ready is high, coef_we writes coef_data (16-bit two's complement) to tap index coef_addr. A write made in the same cycle as an accepted sample is already used for that sample.
- R10: coef_we has no effect while in_ready is low. This includes the post-reset sweep.
- R11: out_data keeps the last result until the next out_valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | DATA_W | Sample, two's complement |
| in_ready | output | 1 | Engine idle, sample will be taken |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | DATA_W | Rounded, saturated result |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | log2(TAPS) | Tap index to write |
| coef_data | input | DATA_W | Coefficient, two's complement |

## Verification
The bench goes after the pointer corner cases. An impulse after reset must trace the coefficients in tap order and then vanish after TAPS more samples. A design that wrapped the wrong way would output the coefficients reversed, and one that kept stale history would leave a residue where a zero is expected. Rounding is probed at exactly half an LSB on both signs, where truncation or round-to-zero gives an off-by-one, and saturation is forced at both rails, where wrapping would flip the sign. Coefficient writes are made during the reset sweep, during a computation and in the accepting cycle. A missing guard or a missing read bypass shows up there as a changed result. A held in_valid with data changing during the computation exposes any engine that restarts or samples early.

// File: rtl/fir_pkg.sv
package fir_pkg;

  typedef enum logic [1:0] {
    ST_SWEEP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_MAC   = 2'd2,
    ST_DONE  = 2'd3
  } fir_state_e;

endpackage

// File: rtl/fir_dpram.sv
module fir_dpram #(
  parameter int W     = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // write-first: a read of the location being written returns the new word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && (waddr == raddr)) rdata <= wdata;
    else                        rdata <= mem[raddr];
  end

endmodule

// File: rtl/fir_csa_mac.sv
module fir_csa_mac #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int ACC_W = 35
) (
  input  logic signed [A_W-1:0]   mul_a,
  input  logic signed [B_W-1:0]   mul_b,
  input  logic signed [ACC_W-1:0] addend,
  output logic signed [ACC_W-1:0] result
);

  logic [ACC_W-1:0] a_ext;
  logic [ACC_W-1:0] pp  [B_W];
  logic [ACC_W-1:0] sv  [B_W+1];
  logic [ACC_W-1:0] cv  [B_W+1];

  assign a_ext = ACC_W'(mul_a);

  // partial products; the sign bit of b carries negative weight,
  // so its row is inverted and the +1 enters through the first carry vector
  for (genvar i = 0; i < B_W; i++) begin : g_pp
    if (i < B_W - 1) begin : g_pos
      assign pp[i] = mul_b[i] ? (a_ext << i) : '0;
    end else begin : g_neg
      assign pp[i] = mul_b[i] ? ~(a_ext << i) : '0;
    end
  end

  assign sv[0] = addend;
  assign cv[0] = ACC_W'(mul_b[B_W-1]);

  // chain of 3:2 compressors: running sum + running carry + one row per stage
  for (genvar j = 0; j < B_W; j++) begin : g_csa
    assign sv[j+1] = sv[j] ^ cv[j] ^ pp[j];
    assign cv[j+1] = ((sv[j] & cv[j]) | (sv[j] & pp[j]) | (cv[j] & pp[j])) << 1;
  end

  assign result = sv[B_W] + cv[B_W];

endmodule

// File: rtl/fir_round_sat.sv
module fir_round_sat #(
  parameter int IN_W  = 35,
  parameter int OUT_W = 16,
  parameter int FRAC  = 15
) (
  input  logic signed [IN_W-1:0]  acc_i,
  output logic signed [OUT_W-1:0] y_o
);

  localparam int EW = IN_W + 1;
  localparam logic signed [EW-1:0] HALF = EW'(1) << (FRAC - 1);
  localparam logic signed [EW-1:0] MAXV = EW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [EW-1:0] MINV = ~MAXV;

  logic signed [EW-1:0] biased;
  logic signed [EW-1:0] shifted;

  always_comb begin
    biased  = $signed({acc_i[IN_W-1], acc_i}) + HALF;
    shifted = biased >>> FRAC;
    if (shifted > MAXV)      y_o = MAXV[OUT_W-1:0];
    else if (shifted < MINV) y_o = MINV[OUT_W-1:0];
    else                     y_o = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine
  import fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAPS   = 8,
  parameter int FRAC   = DATA_W - 1,
  localparam int AW    = $clog2(TAPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              coef_we,
  input  logic [AW-1:0]     coef_addr,
  input  logic [DATA_W-1:0] coef_data
);

  localparam int ACC_W = 2 * DATA_W + AW;
  localparam logic [AW-1:0] LAST = AW'(TAPS - 1);

  if (TAPS < 2 || (1 << AW) != TAPS) begin : g_bad_taps
    $error("TAPS must be a power of two of at least 2");
  end

  fir_state_e state;
  logic [AW-1:0] sweep_idx, wr_ptr, rd_ptr, cf_ptr, tap;
  logic signed [ACC_W-1:0] acc, mac_c, mac_r;
  logic signed [DATA_W-1:0] rs_y;
  logic [DATA_W-1:0] smp_q, cof_q;
  logic accept, sweeping;

  logic              smp_we;
  logic [AW-1:0]     smp_wa, smp_ra;
  logic [DATA_W-1:0] smp_wd;
  logic              cof_we;
  logic [AW-1:0]     cof_wa, cof_ra;
  logic [DATA_W-1:0] cof_wd;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;
  assign sweeping = (state == ST_SWEEP);

  // sample history: written at wr_ptr, read backwards from newest
  assign smp_we = sweeping | accept;
  assign smp_wa = sweeping ? sweep_idx : wr_ptr;
  assign smp_wd = sweeping ? '0 : in_data;
  assign smp_ra = (state == ST_MAC) ? rd_ptr : wr_ptr;

  // coefficients: writable only when idle, read forwards from tap 0
  assign cof_we = sweeping | (in_ready & coef_we);
  assign cof_wa = sweeping ? sweep_idx : coef_addr;
  assign cof_wd = sweeping ? '0 : coef_data;
  assign cof_ra = (state == ST_MAC) ? cf_ptr : '0;

  fir_dpram #(.W(DATA_W), .DEPTH(TAPS)) i_smp_ram (
    .clk   (clk),
    .we    (smp_we),
    .waddr (smp_wa),
    .wdata (smp_wd),
    .raddr (smp_ra),
    .rdata (smp_q)
  );

  fir_dpram #(.W(DATA_W), .DEPTH(TAPS)) i_cof_ram (
    .clk   (clk),
    .we    (cof_we),
    .waddr (cof_wa),
    .wdata (cof_wd),
    .raddr (cof_ra),
    .rdata (cof_q)
  );

  assign mac_c = (tap == '0) ? '0 : acc;

  fir_csa_mac #(.A_W(DATA_W), .B_W(DATA_W), .ACC_W(ACC_W)) i_mac (
    .mul_a  ($signed(smp_q)),
    .mul_b  ($signed(cof_q)),
    .addend (mac_c),
    .result (mac_r)
  );

  fir_round_sat #(.IN_W(ACC_W), .OUT_W(DATA_W), .FRAC(FRAC)) i_rsat (
    .acc_i (acc),
    .y_o   (rs_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SWEEP;
      sweep_idx <= '0;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      cf_ptr    <= '0;
      tap       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_SWEEP: begin
          sweep_idx <= sweep_idx + AW'(1);
          if (sweep_idx == LAST) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= wr_ptr - AW'(1);
            cf_ptr <= AW'(1);
            tap    <= '0;
            state  <= ST_MAC;
          end
        end
        ST_MAC: begin
          acc    <= mac_r;
          rd_ptr <= rd_ptr - AW'(1);
          cf_ptr <= cf_ptr + AW'(1);
          tap    <= tap + AW'(1);
          if (tap == LAST) state <= ST_DONE;
        end
        default: begin
          out_data  <= rs_y;
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // independent behavioural product used only by the checks below
  logic signed [ACC_W-1:0] chk_ref;
  assign chk_ref = ACC_W'($signed(smp_q) * $signed(cof_q)) + mac_c;

  // R1
  sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
    (sweeping && sweep_idx == LAST) |=> in_ready);

  // R2
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R3
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> !in_ready);

  // R3
  ready_at_result_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);

  // R4
  csa_product_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_MAC) |=> (acc == $past(chk_ref)));

endmodule

// File: tb/test_fir_mac_engine.sv
`timescale 1ns/1ps
module test_fir_mac_engine;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  fir_mac_engine #(.DATA_W(16), .TAPS(N)) i_fir_mac_engine (
    .clk, .rst, .in_valid, .in_data, .in_ready, .out_valid, .out_data,
    .coef_we, .coef_addr, .coef_data
  );

  always #2 clk = ~clk;

  int    n_tests = 0;
  int    n_fail  = 0;
  string tag = "R1";
  bit    done = 0;
  int    cyc = 0;
  int    seed = 7;

  // ---------------- behavioural reference ----------------
  int m_state = 0;   // 0 sweep, 1 idle, 2 busy
  int m_ccnt, m_cnt;
  int hist[$];
  int h[N];
  int m_out = 0;
  bit m_ov = 0;

  function automatic int ref_y(int hh[N], int hs[$]);
    longint a = 0;
    longint r;
    for (int k = 0; k < N; k++) a += longint'(hh[k]) * longint'(hs[k]);
    r = (a + 64'sd16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  always @(posedge clk) begin
    m_ov = 0;
    if (rst) begin
      m_state = 0;
      m_ccnt  = N;
      m_out   = 0;
      hist.delete();
      for (int k = 0; k < N; k++) begin hist.push_back(0); h[k] = 0; end
    end else begin
      case (m_state)
        0: begin
          m_ccnt--;
          if (m_ccnt == 0) m_state = 1;
        end
        1: begin
          if (coef_we) h[coef_addr] = int'($signed(coef_data));
          if (in_valid) begin
            hist.push_front(int'($signed(in_data)));
            void'(hist.pop_back());
            m_cnt = N + 1;
            m_state = 2;
          end
        end
        default: begin
          m_cnt--;
          if (m_cnt == 0) begin
            m_out = ref_y(h, hist);
            m_ov = 1;
            m_state = 1;
          end
        end
      endcase
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // compare against the reference every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(in_ready == (m_state == 1), "R3 in_ready", int'(in_ready), int'(m_state == 1));
      chk(out_valid == m_ov, "R2 out_valid", int'(out_valid), int'(m_ov));
      chk(int'($signed(out_data)) == m_out, tag, int'($signed(out_data)), m_out);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  function automatic int rnd16();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[30:15]));
  endfunction

  task automatic wait_ready();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic send(int x, output int lat, output int y);
    wait_ready();
    in_valid = 1'b1;
    in_data  = 16'(x);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!out_valid) begin @(negedge clk); lat++; end
    y = int'($signed(out_data));
  endtask

  task automatic set_coef(int a, int v);
    wait_ready();
    coef_we   = 1'b1;
    coef_addr = 3'(a);
    coef_data = 16'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    wait_ready();
  endtask

  initial begin
    int lat, y, cnt, pulses, held;
    // R10: a coefficient write held through reset and the sweep
    coef_we = 1'b1; coef_addr = 3'd0; coef_data = 16'sd32767;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    chk(!in_ready, "R1 in_ready after reset", int'(in_ready), 0);
    chk(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    chk(out_data == 16'd0, "R1 out_data after reset", int'(out_data), 0);
    cnt = 0;
    while (!in_ready) begin @(negedge clk); cnt++; end
    coef_we = 1'b0;
    chk(cnt == N, "R1 sweep length", cnt, N);

    tag = "R10";
    send(30000, lat, y);
    chk(y == 0, "R10 write during sweep ignored", y, 0);
    chk(lat == N + 1, "R2 latency", lat, N + 1);

    // R6 / R7: impulse response from zero history
    do_reset();
    tag = "R6";
    for (int k = 0; k < N; k++) set_coef(k, 4000 * (k + 1));
    send(16384, lat, y);
    chk(y == 2000, "R6 tap0", y, 2000);
    for (int k = 1; k < N; k++) begin
      send(0, lat, y);
      chk(y == 2000 * (k + 1), "R6 tap order", y, 2000 * (k + 1));
    end
    tag = "R7";
    send(0, lat, y);
    chk(y == 0, "R7 oldest sample dropped", y, 0);

    // R4 / R8: rounding at half an LSB
    tag = "R4";
    set_coef(0, 1);
    for (int k = 1; k < N; k++) set_coef(k, 0);
    send(16384, lat, y);  chk(y == 1, "R4 +half rounds up", y, 1);
    send(16384, lat, y);  chk(y == 1, "R8 accumulator cleared", y, 1);
    send(16383, lat, y);  chk(y == 0, "R4 below half", y, 0);
    send(-16385, lat, y); chk(y == -1, "R4 negative below half", y, -1);
    send(-16384, lat, y); chk(y == 0, "R4 -half rounds up", y, 0);

    // R10: coefficient write while busy
    tag = "R10";
    wait_ready();
    in_valid = 1'b1; in_data = 16'sd16384;
    @(negedge clk);
    in_valid = 1'b0;
    coef_we = 1'b1; coef_addr = 3'd1; coef_data = 16'sd32767;
    repeat (N) @(negedge clk);
    coef_we = 1'b0;
    while (!out_valid) @(negedge clk);
    chk(int'($signed(out_data)) == 1, "R10 busy write result", int'($signed(out_data)), 1);
    send(0, lat, y);
    chk(y == 0, "R10 busy write ignored", y, 0);

    // R9: write in the accepting cycle is used at once
    tag = "R9";
    wait_ready();
    coef_we = 1'b1; coef_addr = 3'd0; coef_data = 16'sd4;
    in_valid = 1'b1; in_data = 16'sd16384;
    @(negedge clk);
    coef_we = 1'b0; in_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    y = int'($signed(out_data));
    chk(y == 2, "R9 same-cycle write", y, 2);

    // R11: result holds
    tag = "R11";
    held = y;
    repeat (5) @(negedge clk);
    chk(int'($signed(out_data)) == held && !out_valid, "R11 hold", int'($signed(out_data)), held);

    // R5: both rails
    tag = "R5";
    for (int k = 0; k < N; k++) set_coef(k, 32767);
    for (int k = 0; k < N; k++) send(32767, lat, y);
    chk(y == 32767, "R5 positive saturation", y, 32767);
    for (int k = 0; k < N; k++) send(-32768, lat, y);
    chk(y == -32768, "R5 negative saturation", y, -32768);

    // R3: held in_valid, data changing while busy
    tag = "R3";
    for (int k = 0; k < N; k++) set_coef(k, rnd16());
    wait_ready();
    in_valid = 1'b1;
    pulses = 0;
    for (int i = 0; i < 5 * (N + 2); i++) begin
      in_data = 16'(rnd16());
      @(negedge clk);
      if (out_valid) pulses++;
    end
    in_valid = 1'b0;
    chk(pulses == 5, "R3 one output per TAPS+2 cycles", pulses, 5);

    // R7: longer random stream over several wraps
    tag = "R7";
    for (int k = 0; k < N; k++) set_coef(k, rnd16());
    for (int i = 0; i < 3 * N; i++) send(rnd16(), lat, y);

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule